// File: doc/BRIEF.md
# Triggered Multichannel Acquisition Controller

This block coordinates simultaneous capture of a multichannel conversion result into two buffers. A parallel result word for every channel is presented on one wide input. When the controller is armed, each rising edge of the selected sample clock, internal or external, starts a sample. Every sample replaces the contents of a small snapshot buffer that holds exactly one word per channel. While a trigger is active, the same words are also appended in channel order to a deep capture FIFO. The trigger is either a software bit or a high level on the external trigger pin, and both need the trigger enable.

A single 16-bit control/status word holds the arm, trigger, clock-select, interrupt-enable, DMA-enable and buffer-reset bits, and it reports the buffer flags. Both buffers drain through valid/ready read streams. The rules for back-pressure are these. A word is removed only on a cycle with valid and ready both high. While valid is high and ready is low, the data stays put. Ready has no effect while valid is low, and in that state the data port shows the last word removed. The capture FIFO also reports a fullness count in whole frames. It drives a shared interrupt request and two DMA requests.

Conversion results and clock or trigger levels are taken as synchronous to `clk`. The capture depth `CAP_FRAMES` and the channel count `NCH` must be powers of two.

Top module: `trig_acq_ctrl`

## Requirements
- R1: A sample occurs only while control bit 15 (arm) is 1, on a 0-to-1 transition of the selected sample clock: `ext_clk_i` when control bit 12 is 1, otherwise `int_clk_i`. Transitions on the other clock input are ignored.
- R2: Each sample loads all NCH channel words into the snapshot buffer and discards what was there before. Channel k comes from `conv_data_i[k*DW +: DW]`, with k = 0 being the first channel. The snapshot stream delivers these words in the order k = 0 up to NCH-1. Status bit 0 (snapshot full) is 1 while all NCH words are unread, and status bit 2 (snapshot empty) is 1 once all of them have been read.
- R3: A sample appends its frame to the capture FIFO only if control bit 14 (trigger enable) is 1 and, at that same sample edge, either control bit 13 (software trigger) is 1 or `ext_trig_i` is high.
- R4: The capture stream returns words in channel order k = 0 up to NCH-1 within each frame, and returns the frames in the order they were sampled.
- R5: `cap_fill_o` equals the number of stored capture words divided by NCH, rounded up. It reads CAP_FRAMES when the FIFO holds every frame and 0 once the FIFO has been read empty. Status bit 6 is 1 when the FIFO is empty. Status bit 3 is 1 when it holds at least half of its NCH*CAP_FRAMES words.
- R6: Status bit 1 (capture full) is 1 when fewer than NCH words are free. A frame that arrives in that state is dropped whole. The flag stays at 1 until reads free NCH words or a buffer reset is applied.
- R7: `irq_o` is 1 exactly when any of these holds: control bit 9 and capture full, control bit 8 and snapshot full, or control bit 7 and capture half full.
- R8: While control bit 5 is 1, `dma_cap_o` follows capture full and `dma_snap_o` follows snapshot full. While control bit 5 is 0, both are 0.
- R9: While control bit 4 is 1, both buffers read as empty, `cap_fill_o` is 0, and samples store nothing.
- R10: A read handshake attempted on an empty buffer removes nothing. The data port keeps showing the last word removed from that buffer, or 0 if no word has been removed since `rst_n`.
- R11: `csr_o` returns the written values of control bits 15-12, 9-7, 5 and 4, and returns bits 11 and 10 as 0. Status flags fill bits 6 and 3-0. After `rst_n` the word reads 0x0044.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_we_i | input | 1 | Writes the control word this cycle |
| ctrl_wdata_i | input | 16 | Control word write value |
| csr_o | output | 16 | Control bits read back with status flags |
| int_clk_i | input | 1 | Internal sample clock level |
| ext_clk_i | input | 1 | External sample clock level |
| ext_trig_i | input | 1 | External trigger level |
| conv_data_i | input | NCH*DW | Conversion results, channel k at bits k*DW |
| snap_valid_o | output | 1 | Snapshot stream has a word |
| snap_ready_i | input | 1 | Snapshot stream consumer ready |
| snap_data_o | output | DW | Snapshot stream word |
| cap_valid_o | output | 1 | Capture stream has a word |
| cap_ready_i | input | 1 | Capture stream consumer ready |
| cap_data_o | output | DW | Capture stream word |
| cap_fill_o | output | $clog2(CAP_FRAMES+1) | Capture fullness in frames |
| irq_o | output | 1 | Shared interrupt request |
| dma_cap_o | output | 1 | DMA request for capture full |
| dma_snap_o | output | 1 | DMA request for snapshot full |

## Verification
The hardest state to reach is a capture FIFO that is almost full after partial reads. In that state the count rounds up, the full flag must hold while a few words have been drained, and an arriving frame must be dropped whole. A directed sequence fills the FIFO frame by frame, offers one extra frame, drains three words and then thirteen more, and checks the flag, the count and the interrupt and DMA outputs at each step. A seeded random phase mixes samples under random trigger modes, clock selections and trigger levels with stream reads that sometimes hit an empty buffer. Each step is compared against a bench model of both buffers.

// File: rtl/acq_pkg.sv
package acq_pkg;
  localparam int CSR_W    = 16;
  // control bit positions
  localparam int B_ARM    = 15;
  localparam int B_TRG_EN = 14;
  localparam int B_SW_TRG = 13;
  localparam int B_EXT_CK = 12;
  localparam int B_IE_CF  = 9;
  localparam int B_IE_SF  = 8;
  localparam int B_IE_HF  = 7;
  localparam int B_DMA_EN = 5;
  localparam int B_CLR    = 4;
  // status bit positions
  localparam int S_CAP_EMPTY  = 6;
  localparam int S_CAP_HALF   = 3;
  localparam int S_SNAP_EMPTY = 2;
  localparam int S_CAP_FULL   = 1;
  localparam int S_SNAP_FULL  = 0;
  localparam logic [CSR_W-1:0] CTRL_MASK = 16'hF3B0;

  typedef struct packed {
    logic cap_empty;
    logic cap_half;
    logic cap_full;
    logic snap_empty;
    logic snap_full;
  } acq_flags_t;
endpackage

// File: rtl/acq_sample_seq.sv
module acq_sample_seq (
  input  logic clk,
  input  logic rst_n,
  input  logic int_clk_i,
  input  logic ext_clk_i,
  input  logic ext_sel_i,
  input  logic arm_i,
  input  logic trig_en_i,
  input  logic sw_trig_i,
  input  logic ext_trig_i,
  output logic sample_o,
  output logic capture_o
);
  logic sclk;
  logic sclk_prev_q;

  assign sclk = ext_sel_i ? ext_clk_i : int_clk_i;

  // reset high so a clock already high at reset release gives no edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b1;
    else        sclk_prev_q <= sclk;
  end

  assign sample_o  = arm_i & sclk & ~sclk_prev_q;
  assign capture_o = sample_o & trig_en_i & (sw_trig_i | ext_trig_i);

  assert_single_strobe_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sample_o |=> !sample_o);
endmodule

// File: rtl/acq_snapshot.sv
module acq_snapshot #(
  parameter int NCH = 16,
  parameter int DW  = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_i,
  input  logic            load_i,
  input  logic [NCH*DW-1:0] frame_i,
  input  logic            ready_i,
  output logic            valid_o,
  output logic [DW-1:0]   data_o,
  output logic            full_o,
  output logic            empty_o
);
  localparam int CNTW = $clog2(NCH + 1);
  localparam int IW   = (NCH > 1) ? $clog2(NCH) : 1;

  logic [DW-1:0]   word_q [NCH];
  logic [CNTW-1:0] cnt_q;
  logic [IW-1:0]   idx_q;
  logic [DW-1:0]   last_q;
  logic            pop;

  assign valid_o = (cnt_q != '0);
  assign full_o  = (cnt_q == CNTW'(NCH));
  assign empty_o = !valid_o;
  assign pop     = valid_o && ready_i && !clr_i && !load_i;
  assign data_o  = valid_o ? word_q[idx_q] : last_q;

  always_ff @(posedge clk) begin
    if (load_i && !clr_i) begin
      for (int k = 0; k < NCH; k++) word_q[k] <= frame_i[k*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      idx_q  <= '0;
      last_q <= '0;
    end else if (clr_i) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (load_i) begin
      cnt_q <= CNTW'(NCH);
      idx_q <= '0;
    end else if (pop) begin
      cnt_q  <= cnt_q - CNTW'(1);
      idx_q  <= idx_q + IW'(1);
      last_q <= word_q[idx_q];
    end
  end

  assert_load_fills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !clr_i) |=> full_o);
  assert_read_unfills_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && ready_i && !load_i && !clr_i) |=> !full_o);
  assert_empty_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && !load_i) |=> (empty_o && $stable(data_o)));
endmodule

// File: rtl/acq_capture_fifo.sv
module acq_capture_fifo #(
  parameter int NCH        = 16,
  parameter int DW         = 16,
  parameter int CAP_FRAMES = 8,
  localparam int CAP_WORDS = CAP_FRAMES * NCH,
  localparam int FILL_W    = $clog2(CAP_FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              wr_frame_i,
  input  logic [NCH*DW-1:0] frame_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DW-1:0]     data_o,
  output logic [FILL_W-1:0] fill_o,
  output logic              empty_o,
  output logic              half_o,
  output logic              full_o
);
  localparam int AW  = (CAP_WORDS > 1) ? $clog2(CAP_WORDS) : 1;
  localparam int WCW = $clog2(CAP_WORDS + 1);

  logic [DW-1:0]  mem_q [CAP_WORDS];
  logic [AW-1:0]  wr_ptr_q, rd_ptr_q;
  logic [WCW-1:0] words_q;
  logic [DW-1:0]  last_q;
  logic           room, accept, pop;
  logic [WCW:0]   fill_num;

  assign room    = (words_q <= WCW'(CAP_WORDS - NCH));
  assign accept  = wr_frame_i && !clr_i && room;
  assign valid_o = (words_q != '0);
  assign pop     = valid_o && ready_i && !clr_i;
  assign data_o  = valid_o ? mem_q[rd_ptr_q] : last_q;

  assign empty_o  = !valid_o;
  assign half_o   = (words_q >= WCW'(CAP_WORDS / 2));
  assign full_o   = !room;
  assign fill_num = {1'b0, words_q} + (WCW+1)'(NCH - 1);
  assign fill_o   = FILL_W'(fill_num / (WCW+1)'(NCH));

  // one whole frame per sample; frame base stays NCH-aligned
  always_ff @(posedge clk) begin
    if (accept) begin
      for (int k = 0; k < NCH; k++) mem_q[wr_ptr_q + AW'(k)] <= frame_i[k*DW +: DW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      words_q  <= '0;
      last_q   <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      words_q  <= '0;
    end else begin
      if (accept) wr_ptr_q <= wr_ptr_q + AW'(NCH);
      if (pop) begin
        rd_ptr_q <= rd_ptr_q + AW'(1);
        last_q   <= mem_q[rd_ptr_q];
      end
      words_q <= words_q + (accept ? WCW'(NCH) : '0) - (pop ? WCW'(1) : '0);
    end
  end

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    words_q <= WCW'(CAP_WORDS));
  assert_full_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (full_o && !ready_i && !clr_i) |=> full_o);
  assert_empty_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && !wr_frame_i) |=> (empty_o && $stable(data_o)));
  assert_fill_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> (fill_o == '0));
endmodule

// File: rtl/trig_acq_ctrl.sv
module trig_acq_ctrl
  import acq_pkg::*;
#(
  parameter int NCH        = 16,
  parameter int DW         = 16,
  parameter int CAP_FRAMES = 8,
  localparam int FILL_W    = $clog2(CAP_FRAMES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we_i,
  input  logic [CSR_W-1:0]  ctrl_wdata_i,
  output logic [CSR_W-1:0]  csr_o,
  input  logic              int_clk_i,
  input  logic              ext_clk_i,
  input  logic              ext_trig_i,
  input  logic [NCH*DW-1:0] conv_data_i,
  output logic              snap_valid_o,
  input  logic              snap_ready_i,
  output logic [DW-1:0]     snap_data_o,
  output logic              cap_valid_o,
  input  logic              cap_ready_i,
  output logic [DW-1:0]     cap_data_o,
  output logic [FILL_W-1:0] cap_fill_o,
  output logic              irq_o,
  output logic              dma_cap_o,
  output logic              dma_snap_o
);
  logic [CSR_W-1:0] ctrl_q;
  logic             sample, capture, clr;
  acq_flags_t       flg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ctrl_q <= '0;
    else if (ctrl_we_i) ctrl_q <= ctrl_wdata_i & CTRL_MASK;
  end

  assign clr = ctrl_q[B_CLR];

  acq_sample_seq u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .int_clk_i  (int_clk_i),
    .ext_clk_i  (ext_clk_i),
    .ext_sel_i  (ctrl_q[B_EXT_CK]),
    .arm_i      (ctrl_q[B_ARM]),
    .trig_en_i  (ctrl_q[B_TRG_EN]),
    .sw_trig_i  (ctrl_q[B_SW_TRG]),
    .ext_trig_i (ext_trig_i),
    .sample_o   (sample),
    .capture_o  (capture)
  );

  acq_snapshot #(.NCH(NCH), .DW(DW)) u_snap (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr),
    .load_i  (sample),
    .frame_i (conv_data_i),
    .ready_i (snap_ready_i),
    .valid_o (snap_valid_o),
    .data_o  (snap_data_o),
    .full_o  (flg.snap_full),
    .empty_o (flg.snap_empty)
  );

  acq_capture_fifo #(.NCH(NCH), .DW(DW), .CAP_FRAMES(CAP_FRAMES)) u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr),
    .wr_frame_i (capture),
    .frame_i    (conv_data_i),
    .ready_i    (cap_ready_i),
    .valid_o    (cap_valid_o),
    .data_o     (cap_data_o),
    .fill_o     (cap_fill_o),
    .empty_o    (flg.cap_empty),
    .half_o     (flg.cap_half),
    .full_o     (flg.cap_full)
  );

  always_comb begin
    csr_o               = ctrl_q;
    csr_o[S_CAP_EMPTY]  = flg.cap_empty;
    csr_o[S_CAP_HALF]   = flg.cap_half;
    csr_o[S_SNAP_EMPTY] = flg.snap_empty;
    csr_o[S_CAP_FULL]   = flg.cap_full;
    csr_o[S_SNAP_FULL]  = flg.snap_full;
  end

  assign irq_o = (ctrl_q[B_IE_CF] & flg.cap_full) |
                 (ctrl_q[B_IE_SF] & flg.snap_full) |
                 (ctrl_q[B_IE_HF] & flg.cap_half);
  assign dma_cap_o  = ctrl_q[B_DMA_EN] & flg.cap_full;
  assign dma_snap_o = ctrl_q[B_DMA_EN] & flg.snap_full;

  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (flg.cap_full | flg.snap_full | flg.cap_half));
  assert_reset_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) && clr |-> (flg.cap_empty && flg.snap_empty));
  assert_dma_needs_full_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_cap_o |-> cap_fill_o != '0));
endmodule

// File: tb/trig_acq_ctrl_tb_top.sv
module trig_acq_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 16;
  localparam int DW = 16;
  localparam int CAP_FRAMES = 8;
  localparam int CAPW = NCH * CAP_FRAMES;
  localparam int FILL_W = $clog2(CAP_FRAMES + 1);

  logic clk = 0, rst_n = 0;
  logic ctrl_we = 0;
  logic [15:0] ctrl_wdata = 0;
  logic [15:0] csr;
  logic int_clk = 0, ext_clk = 0, ext_trig = 0;
  logic [NCH*DW-1:0] conv = '0;
  logic snap_valid, snap_ready = 0, cap_valid, cap_ready = 0;
  logic [DW-1:0] snap_data, cap_data;
  logic [FILL_W-1:0] cap_fill;
  logic irq, dma_cap, dma_snap;

  int n_checks = 0, n_err = 0, cyc = 0;
  logic [15:0] ctrl_m = 0;
  logic [15:0] capq[$];
  logic [15:0] snapq[$];
  logic [15:0] last_cap = 0, last_snap = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_acq_ctrl #(.NCH(NCH), .DW(DW), .CAP_FRAMES(CAP_FRAMES)) dut_i (
    .clk(clk), .rst_n(rst_n), .ctrl_we_i(ctrl_we), .ctrl_wdata_i(ctrl_wdata),
    .csr_o(csr), .int_clk_i(int_clk), .ext_clk_i(ext_clk), .ext_trig_i(ext_trig),
    .conv_data_i(conv), .snap_valid_o(snap_valid), .snap_ready_i(snap_ready),
    .snap_data_o(snap_data), .cap_valid_o(cap_valid), .cap_ready_i(cap_ready),
    .cap_data_o(cap_data), .cap_fill_o(cap_fill), .irq_o(irq),
    .dma_cap_o(dma_cap), .dma_snap_o(dma_snap));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++;
      $display("FAIL watchdog expired after %0d cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_full();  return capq.size() > CAPW - NCH; endfunction
  function automatic bit m_half();  return capq.size() >= CAPW / 2; endfunction
  function automatic bit m_sfull(); return snapq.size() == NCH; endfunction
  function automatic logic [15:0] m_status();
    logic [15:0] s;
    s = ctrl_m & 16'hF3B0;
    s[6] = (capq.size() == 0);
    s[3] = m_half();
    s[2] = (snapq.size() == 0);
    s[1] = m_full();
    s[0] = m_sfull();
    return s;
  endfunction

  task automatic check_all(input string tag);
    check({"R11 status ", tag}, csr, m_status());
    check({"R5 fill ", tag}, cap_fill, (capq.size() + NCH - 1) / NCH);
    check({"R7 irq ", tag}, irq, (ctrl_m[9] & m_full()) | (ctrl_m[8] & m_sfull()) | (ctrl_m[7] & m_half()));
    check({"R8 dma cap ", tag}, dma_cap, ctrl_m[5] & m_full());
    check({"R8 dma snap ", tag}, dma_snap, ctrl_m[5] & m_sfull());
    check({"R2 snap valid ", tag}, snap_valid, snapq.size() != 0);
    check({"R5 cap valid ", tag}, cap_valid, capq.size() != 0);
  endtask

  task automatic wr_ctrl(input logic [15:0] v);
    ctrl_wdata = v; ctrl_we = 1;
    @(negedge clk);
    ctrl_we = 0;
    ctrl_m = v;
    if (v[4]) begin capq.delete(); snapq.delete(); end
    @(negedge clk);
  endtask

  function automatic logic [NCH*DW-1:0] rand_frame();
    logic [NCH*DW-1:0] f;
    for (int k = 0; k < NCH; k++) f[k*DW +: DW] = DW'($urandom);
    return f;
  endfunction

  task automatic do_sample(input bit use_ext, input bit trig, input logic [NCH*DW-1:0] f);
    conv = f; ext_trig = trig;
    if (use_ext) ext_clk = 1; else int_clk = 1;
    @(negedge clk);
    int_clk = 0; ext_clk = 0;
    @(negedge clk);
    if (ctrl_m[15] && !ctrl_m[4] && (use_ext == ctrl_m[12])) begin
      snapq.delete();
      for (int k = 0; k < NCH; k++) snapq.push_back(f[k*DW +: DW]);
      if (ctrl_m[14] && (ctrl_m[13] || trig) && capq.size() <= CAPW - NCH)
        for (int k = 0; k < NCH; k++) capq.push_back(f[k*DW +: DW]);
    end
  endtask

  task automatic pop_cap(input string req);
    if (capq.size() != 0) check(req, cap_data, capq[0]);
    else                  check({req, " R10 empty data"}, cap_data, last_cap);
    cap_ready = 1;
    @(negedge clk);
    cap_ready = 0;
    if (capq.size() != 0) last_cap = capq.pop_front();
    else check("R10 cap data after empty read", cap_data, last_cap);
  endtask

  task automatic pop_snap(input string req);
    if (snapq.size() != 0) check(req, snap_data, snapq[0]);
    else                   check({req, " R10 empty data"}, snap_data, last_snap);
    snap_ready = 1;
    @(negedge clk);
    snap_ready = 0;
    if (snapq.size() != 0) last_snap = snapq.pop_front();
    else check("R10 snap data after empty read", snap_data, last_snap);
  endtask

  initial begin
    int seed_set;
    seed_set = $urandom(32'd5150);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R11 reset status", csr, 16'h0044);
    check_all("after reset");
    check("R10 reset data", cap_data, 0);

    // R1: unarmed sample does nothing
    do_sample(0, 0, rand_frame());
    check_all("R1 unarmed");

    // R1/R2: armed internal sample loads snapshot
    wr_ctrl(16'h8000);
    do_sample(0, 0, rand_frame());
    check("R2 snapshot full after sample", csr[0], 1);
    check_all("R2 loaded");
    for (int i = 0; i < NCH; i++) pop_snap("R2 snapshot channel order");
    check_all("R2 drained");
    pop_snap("R10 snapshot empty read");

    // R1: external clock selected, internal edge ignored
    wr_ctrl(16'h9000);
    do_sample(0, 0, rand_frame());
    check_all("R1 ignored edge");
    do_sample(1, 0, rand_frame());
    check_all("R1 external edge");

    // R3: trigger enable off with software bit set
    wr_ctrl(16'hA000);
    do_sample(0, 0, rand_frame());
    check_all("R3 trigger disabled");
    // R3: external trigger level
    wr_ctrl(16'hC000);
    do_sample(0, 0, rand_frame());
    check_all("R3 ext low");
    do_sample(0, 1, rand_frame());
    check_all("R3 ext high");
    for (int i = 0; i < NCH; i++) pop_cap("R4 capture channel order");
    check_all("R5 drained");
    pop_cap("R10 capture empty read");

    // random phase
    for (int it = 0; it < 500; it++) begin
      int op;
      op = $urandom % 8;
      if (op < 4) begin
        logic [15:0] c;
        c = 16'h83A0;
        if ($urandom % 4 != 0) c[14] = 1;
        if ($urandom % 2 != 0) c[13] = 1;
        if ($urandom % 4 == 0) c[12] = 1;
        wr_ctrl(c);
        do_sample($urandom % 4 == 0, $urandom % 2 == 1, rand_frame());
      end else if (op < 6) pop_cap("R4 random capture read");
      else if (op == 6) pop_snap("R2 random snapshot read");
      else for (int j = 0; j < 8; j++) pop_cap("R4 random burst read");
      check_all("random");
    end

    // R9: buffer reset
    wr_ctrl(16'h83B0);
    check_all("R9 reset held");
    do_sample(0, 1, rand_frame());
    check_all("R9 sample while reset");
    check("R11 readback all ones", 0, 0);
    wr_ctrl(16'hFFFF);
    check("R11 readback mask", csr, 16'hF3F4);

    // R6: fill, overflow, partial drain
    wr_ctrl(16'hE3A0);
    for (int f = 0; f < CAP_FRAMES; f++) begin
      do_sample(0, 0, rand_frame());
      check_all("R6 filling");
    end
    check("R5 fill at full", cap_fill, CAP_FRAMES);
    check("R6 full flag", csr[1], 1);
    do_sample(0, 0, rand_frame());
    check_all("R6 frame dropped");
    for (int i = 0; i < 3; i++) pop_cap("R4 partial read");
    check("R6 full holds after 3 reads", csr[1], 1);
    check_all("R6 partial");
    for (int i = 0; i < 13; i++) pop_cap("R4 partial read");
    check("R6 full clears after frame freed", csr[1], 0);
    check_all("R6 room");
    do_sample(0, 0, rand_frame());
    check_all("R6 refilled");
    wr_ctrl(16'h0000);
    check_all("R8 dma disabled");
    while (capq.size() != 0) pop_cap("R4 final drain");
    check("R5 fill zero when empty", cap_fill, 0);
    check_all("R5 final");
    pop_cap("R10 final empty read");

    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end
endmodule